// File: doc/BRIEF.md
# Burst Memory WAIT Generator

This block paces synchronous bursts inside a pseudo-static memory. A burst opens when chip enable and address valid are both low at a clock edge. The block then holds WAIT active until the first word can move. After that it steps the column address and pulses a read or write strobe once per clock. It also stretches an access when it collides with an internal refresh, and it stalls for two cycles whenever a continuous burst runs past the end of a 128-word row.

A small refresh arbiter sits beside the burst sequencer. A request from the refresh timer is held pending until the memory is idle or in a row-crossing stall, and the refresh then occupies four clocks. One configuration input sets whether WAIT lines up with the stalled cycles or leads them by one cycle. A second input sets the active level of WAIT, so that the pin can share a wired ready line with other devices.

Top module: `burst_wait_gen`

## Requirements
- R1: After reset, WAIT is at its inactive level, both strobes are low and the corruption flag is low.
- R2: A burst starts on a clock edge where `ce_n` and `adv_n` are both low while no burst is active. With aligned timing, the first word moves in the L-th cycle after that edge, where L is `latency` forced into the range 2 to 6.
- R3: Once data flows, one word moves per clock and the column rises by one each word. The word shows on `rd_stb` when `we_n` was high at the start edge and on `wr_stb` when it was low; the two strobes are never high together.
- R4: A refresh lasts 4 clocks. While a refresh is busy during the initial latency, the latency count is frozen, so the first word slips by the remaining refresh cycles.
- R5: A refresh request is started only when no burst is active or when a row-crossing stall is in progress. Otherwise it stays pending.
- R6: When a word moves at a column whose low 7 bits are all ones and `ce_n` stays low, the next 2 cycles are stall cycles.
- R7: A refresh pending at a row crossing starts at the crossing, and the stall lasts until both the 2 row cycles and the refresh are done.
- R8: With `wait_align` = 1, WAIT is active in exactly those cycles of an active burst in which no word moves.
- R9: With `wait_align` = 0, WAIT keeps its timing, while the strobes and `col_addr` appear one cycle later. Wait cycles therefore end one cycle after WAIT drops and begin one cycle after WAIT rises.
- R10: WAIT is driven high when active if `wait_hi` = 1, and low when active if `wait_hi` = 0.
- R11: If `ce_n` is high at the end of a stall cycle, the burst aborts and `corrupt` pulses high for the next cycle. Raising `ce_n` in a data cycle ends the burst with no flag.
- R12: `adv_n` and `start_addr` are ignored while a burst is active. The column keeps counting from its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, low active |
| adv_n | input | 1 | Address valid, low active |
| we_n | input | 1 | Write enable, low means write burst |
| start_addr | input | ADDR_W | Column address latched at burst start |
| latency | input | LAT_W | Requested initial latency in clocks |
| wait_align | input | 1 | 1: WAIT aligned with stall cycles, 0: WAIT leads by one cycle |
| wait_hi | input | 1 | Active level of WAIT |
| ref_req | input | 1 | Refresh request from the refresh timer |
| wait_o | output | 1 | WAIT output |
| rd_stb | output | 1 | Read word valid |
| wr_stb | output | 1 | Write word accepted |
| col_addr | output | ADDR_W | Column of the word currently moving |
| corrupt | output | 1 | Pulse marking an abort during a stall |

## Verification
The bench builds the block with its default parameters: 16-bit columns, 7 row bits, 3 latency bits, a 4-clock refresh and a 2-cycle row stall. Start addresses just below a row end bring a crossing within two or three words. Short latencies let a refresh raised mid-burst stay pending until that crossing. A 3-bit latency input also reaches the values 0 and 7, so the clamp to both ends of the 2 to 6 range is exercised.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    typedef struct packed {
        logic active;
        logic stall;
        logic xfer;
        dir_e dir;
        logic row_busy;
        logic row_start;
    } seq_stat_t;

    function automatic int unsigned clamp_lat(input int unsigned req,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/bwg_refresh.sv
module bwg_refresh #(
    parameter int unsigned REF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_req,
    input  logic can_start,
    output logic ref_busy
);
    localparam int unsigned RF_W = $clog2(REF_CYC + 1);

    logic [RF_W-1:0] cnt;
    logic            pend;

    assign ref_busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (ref_req) pend <= 1'b1;
        end else if ((pend || ref_req) && can_start) begin
            cnt  <= RF_W'(REF_CYC);
            pend <= 1'b0;
        end else if (ref_req) begin
            pend <= 1'b1;
        end
    end

    // R5
    ref_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_busy) |-> $past(can_start));

    // R5
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !can_start && !ref_busy) |=> !ref_busy);

endmodule

// File: rtl/bwg_seq.sv
module bwg_seq
    import bwg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned ROW_BITS  = 7,
    parameter int unsigned LAT_W     = 3,
    parameter int unsigned LAT_MIN   = 2,
    parameter int unsigned LAT_MAX   = 6,
    parameter int unsigned ROW_STALL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LAT_W-1:0]  latency,
    input  logic              ref_busy,
    output seq_stat_t         stat,
    output logic [ADDR_W-1:0] col,
    output logic              corrupt
);
    localparam int unsigned RS_W = $clog2(ROW_STALL + 1);

    logic             active;
    logic [LAT_W-1:0] lat_cnt;
    logic [RS_W-1:0]  row_cnt;
    dir_e             dir;
    logic [LAT_W-1:0] lat_load;
    logic             stall, xfer, row_end, row_start;

    assign lat_load  = LAT_W'(clamp_lat(32'(latency), LAT_MIN, LAT_MAX) - 1);
    assign stall     = active && (lat_cnt != '0 || row_cnt != '0 || ref_busy);
    assign xfer      = active && !stall;
    assign row_end   = &col[ROW_BITS-1:0];
    assign row_start = xfer && !ce_n && row_end;

    always_comb begin
        stat           = '0;
        stat.active    = active;
        stat.stall     = stall;
        stat.xfer      = xfer;
        stat.dir       = dir;
        stat.row_busy  = (row_cnt != '0);
        stat.row_start = row_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            lat_cnt <= '0;
            row_cnt <= '0;
            col     <= '0;
            dir     <= DIR_RD;
            corrupt <= 1'b0;
        end else begin
            corrupt <= active && ce_n && stall;
            if (!active) begin
                if (!ce_n && !adv_n) begin
                    active  <= 1'b1;
                    col     <= start_addr;
                    lat_cnt <= lat_load;
                    row_cnt <= '0;
                    dir     <= we_n ? DIR_RD : DIR_WR;
                end
            end else if (ce_n) begin
                active  <= 1'b0;
                lat_cnt <= '0;
                row_cnt <= '0;
            end else if (xfer) begin
                col <= col + ADDR_W'(1);
                if (row_end) row_cnt <= RS_W'(ROW_STALL);
            end else begin
                if (lat_cnt != '0 && !ref_busy) lat_cnt <= lat_cnt - 1'b1;
                if (row_cnt != '0) row_cnt <= row_cnt - 1'b1;
            end
        end
    end

    // R11
    abort_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (active && ce_n && stall) |=> corrupt);

    // R11
    end_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(ce_n));

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && !ce_n) |=> (col == $past(col) + ADDR_W'(1)));

    // R12
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !ce_n && !xfer) |=> $stable(col));

    // R6
    row_stall_chk: assert property (@(posedge clk) disable iff (rst)
        row_start |=> stall);

endmodule

// File: rtl/bwg_align.sv
module bwg_align
    import bwg_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wait_align,
    input  logic              wait_hi,
    input  logic              stall,
    input  logic              xfer,
    input  dir_e              dir,
    input  logic [ADDR_W-1:0] col,
    output logic              wait_o,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] col_addr
);
    logic              now_rd, now_wr, lag_rd, lag_wr;
    logic [ADDR_W-1:0] lag_col;

    assign now_rd = xfer && (dir == DIR_RD);
    assign now_wr = xfer && (dir == DIR_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            lag_rd  <= 1'b0;
            lag_wr  <= 1'b0;
            lag_col <= '0;
        end else begin
            lag_rd  <= now_rd;
            lag_wr  <= now_wr;
            lag_col <= col;
        end
    end

    assign wait_o   = wait_hi ? stall : !stall;
    assign rd_stb   = wait_align ? now_rd : lag_rd;
    assign wr_stb   = wait_align ? now_wr : lag_wr;
    assign col_addr = wait_align ? col : lag_col;

    // R9
    lag_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (!wait_align && $past(!wait_align) && $past(stall)) |-> (!rd_stb && !wr_stb));

    // R3
    one_dir_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stb, wr_stb}));

endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
    import bwg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned ROW_BITS  = 7,
    parameter int unsigned LAT_W     = 3,
    parameter int unsigned LAT_MIN   = 2,
    parameter int unsigned LAT_MAX   = 6,
    parameter int unsigned ROW_STALL = 2,
    parameter int unsigned REF_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LAT_W-1:0]  latency,
    input  logic              wait_align,
    input  logic              wait_hi,
    input  logic              ref_req,
    output logic              wait_o,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] col_addr,
    output logic              corrupt
);
    seq_stat_t         stat;
    logic [ADDR_W-1:0] col;
    logic              ref_busy;
    logic              can_start;

    assign can_start = !stat.active || stat.row_busy || stat.row_start;

    bwg_refresh #(.REF_CYC(REF_CYC)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .ref_req   (ref_req),
        .can_start (can_start),
        .ref_busy  (ref_busy)
    );

    bwg_seq #(
        .ADDR_W   (ADDR_W),
        .ROW_BITS (ROW_BITS),
        .LAT_W    (LAT_W),
        .LAT_MIN  (LAT_MIN),
        .LAT_MAX  (LAT_MAX),
        .ROW_STALL(ROW_STALL)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .adv_n      (adv_n),
        .we_n       (we_n),
        .start_addr (start_addr),
        .latency    (latency),
        .ref_busy   (ref_busy),
        .stat       (stat),
        .col        (col),
        .corrupt    (corrupt)
    );

    bwg_align #(.ADDR_W(ADDR_W)) u_align (
        .clk        (clk),
        .rst        (rst),
        .wait_align (wait_align),
        .wait_hi    (wait_hi),
        .stall      (stat.stall),
        .xfer       (stat.xfer),
        .dir        (stat.dir),
        .col        (col),
        .wait_o     (wait_o),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .col_addr   (col_addr)
    );

    // R8
    wait_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_align && (wait_o == wait_hi)) |-> (!rd_stb && !wr_stb));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(stat.active) && !stat.active) |-> (wait_o != wait_hi));

endmodule

// File: tb/sim_burst_wait_gen.sv
`timescale 1ns/1ps
module sim_burst_wait_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, ref_req = 1'b0;
    logic [15:0] start_addr = '0;
    logic [2:0]  latency = 3'd3;
    logic        wait_align = 1'b1, wait_hi = 1'b1;
    logic        wait_o, rd_stb, wr_stb, corrupt;
    logic [15:0] col_addr;

    int checks = 0, errors = 0, cyc = 0;
    string tag = "R1";

    int m_act, m_lat, m_row, m_ref, m_pend, m_wr, m_cor, m_drd, m_dwr;
    int unsigned m_col, m_dcol;
    bit obs_wait, obs_rd, obs_wr, obs_cor;
    logic [15:0] obs_col;

    burst_wait_gen u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
        .start_addr(start_addr), .latency(latency), .wait_align(wait_align),
        .wait_hi(wait_hi), .ref_req(ref_req), .wait_o(wait_o), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .col_addr(col_addr), .corrupt(corrupt)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual %0d expected <= 20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int clampl(input int v);
        return (v < 2) ? 2 : ((v > 6) ? 6 : v);
    endfunction

    task automatic model_reset();
        m_act = 0; m_lat = 0; m_row = 0; m_ref = 0; m_pend = 0; m_wr = 0;
        m_cor = 0; m_drd = 0; m_dwr = 0; m_col = 0; m_dcol = 0;
    endtask

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", t, act, exp);
        end
    endtask

    // Compare the window now settled, then drive inputs for it and step the model.
    task automatic tick(input bit ce, input bit adv, input bit we,
                        input int unsigned addr, input bit rq);
        bit st, xf, e_wait, e_rd, e_wr, rs, can, bad;
        int unsigned e_col;
        int old_ref;
        @(negedge clk);
        st     = (m_act != 0) && (m_lat > 0 || m_row > 0 || m_ref > 0);
        xf     = (m_act != 0) && !st;
        e_wait = wait_hi ? st : !st;
        e_rd   = wait_align ? (xf && m_wr == 0) : (m_drd != 0);
        e_wr   = wait_align ? (xf && m_wr != 0) : (m_dwr != 0);
        e_col  = wait_align ? m_col : m_dcol;
        bad = (wait_o != e_wait) || (rd_stb != e_rd) || (wr_stb != e_wr) ||
              (corrupt != (m_cor != 0)) || ((e_rd || e_wr) && (col_addr != e_col[15:0]));
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s cyc=%0d wait %b/%b rd %b/%b wr %b/%b col %h/%h cor %b/%b",
                     tag, cyc, wait_o, e_wait, rd_stb, e_rd, wr_stb, e_wr,
                     col_addr, e_col[15:0], corrupt, m_cor[0]);
        end
        obs_wait = (wait_o == wait_hi); obs_rd = rd_stb; obs_wr = wr_stb;
        obs_col = col_addr; obs_cor = corrupt;
        ce_n = ce; adv_n = adv; we_n = we; start_addr = addr[15:0]; ref_req = rq;
        rs  = xf && !ce && ((m_col % 128) == 127);
        can = (m_act == 0) || m_row > 0 || rs;
        old_ref = m_ref;
        m_cor = (m_act != 0 && ce && st) ? 1 : 0;
        m_drd = (xf && m_wr == 0) ? 1 : 0;
        m_dwr = (xf && m_wr != 0) ? 1 : 0;
        m_dcol = m_col;
        if (m_act == 0) begin
            if (!ce && !adv) begin
                m_act = 1; m_col = addr & 16'hFFFF; m_row = 0;
                m_lat = clampl(int'(latency)) - 1; m_wr = we ? 0 : 1;
            end
        end else if (ce) begin
            m_act = 0; m_lat = 0; m_row = 0;
        end else if (xf) begin
            if ((m_col % 128) == 127) m_row = 2;
            m_col = (m_col + 1) & 16'hFFFF;
        end else begin
            if (m_lat > 0 && old_ref == 0) m_lat--;
            if (m_row > 0) m_row--;
        end
        if (m_ref > 0) begin
            m_ref--;
            if (rq) m_pend = 1;
        end else if ((m_pend != 0 || rq) && can) begin
            m_ref = 4; m_pend = 0;
        end else if (rq) m_pend = 1;
    endtask

    task automatic go(input int unsigned addr, input bit we);
        tick(1'b0, 1'b0, we, addr, 1'b0);
    endtask
    task automatic hold(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b1, 0, 1'b0);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1, 1'b1, 0, 1'b0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(wait_o == 1'b0 && !rd_stb && !wr_stb && !corrupt, "R1 reset outputs",
            {wait_o, rd_stb, wr_stb, corrupt}, 0);
        idle(2);

        // R2 R3 R8: read burst, latency 3
        tag = "R8"; latency = 3'd3;
        go(16'h0010, 1'b1);
        hold(2); chk(obs_wait && !obs_rd, "R2 latency 3 still waiting", obs_rd, 0);
        hold(1); chk(obs_rd && obs_col == 16'h0010, "R2 first read word", obs_col, 16'h0010);
        hold(3); chk(obs_rd && obs_col == 16'h0013, "R3 column step", obs_col, 16'h0013);
        idle(3);

        // R3 write burst, latency 6
        tag = "R3"; latency = 3'd6;
        go(16'h0200, 1'b0);
        hold(5); chk(!obs_wr, "R3 write latency 6 waiting", obs_wr, 0);
        hold(1); chk(obs_wr && !obs_rd && obs_col == 16'h0200, "R3 write strobe", obs_col, 16'h0200);
        hold(2); idle(3);

        // R2 clamp low and high
        tag = "R2"; latency = 3'd0;
        go(16'h0030, 1'b1);
        hold(1); chk(!obs_rd, "R2 clamp low w1", obs_rd, 0);
        hold(1); chk(obs_rd, "R2 clamp low first word", obs_rd, 1);
        idle(3);
        latency = 3'd7;
        go(16'h0030, 1'b1);
        hold(5); chk(!obs_rd, "R2 clamp high w5", obs_rd, 0);
        hold(1); chk(obs_rd, "R2 clamp high first word", obs_rd, 1);
        idle(3);

        // R4 refresh collision at burst start
        tag = "R4"; latency = 3'd3;
        tick(1'b1, 1'b1, 1'b1, 0, 1'b1);
        go(16'h0050, 1'b1);
        hold(5); chk(obs_wait && !obs_rd, "R4 latency frozen by refresh", obs_rd, 0);
        hold(1); chk(obs_rd && obs_col == 16'h0050, "R4 first word after refresh", obs_col, 16'h0050);
        hold(2); idle(6);

        // R6 row crossing
        tag = "R6"; latency = 3'd2;
        go(16'h007E, 1'b1);
        hold(3); chk(obs_rd && obs_col == 16'h007F, "R6 last word of row", obs_col, 16'h007F);
        hold(2); chk(obs_wait && !obs_rd, "R6 row stall", obs_rd, 0);
        hold(1); chk(obs_rd && obs_col == 16'h0080, "R6 next row word", obs_col, 16'h0080);
        idle(3);

        // R5 R7 pending refresh taken at the crossing
        tag = "R7";
        go(16'h00FE, 1'b1);
        tick(1'b0, 1'b1, 1'b1, 0, 1'b1);
        hold(6); chk(obs_wait, "R7 stall extended by refresh", obs_wait, 1);
        hold(1); chk(obs_rd && obs_col == 16'h0100, "R5 burst resumes after refresh", obs_col, 16'h0100);
        hold(2); idle(6);

        // R9 early WAIT timing
        tag = "R9"; wait_align = 1'b0;
        go(16'h0020, 1'b1);
        hold(2); chk(!obs_wait && !obs_rd, "R9 WAIT drops before data", obs_rd, 0);
        hold(1); chk(obs_rd && obs_col == 16'h0020, "R9 lagged first word", obs_col, 16'h0020);
        idle(3);
        go(16'h017F, 1'b1);
        hold(6); idle(3);
        wait_align = 1'b1;

        // R10 active-low WAIT
        tag = "R10"; wait_hi = 1'b0;
        idle(1); chk(wait_o == 1'b1, "R10 idle level", wait_o, 1);
        go(16'h0040, 1'b1);
        hold(1); chk(wait_o == 1'b0, "R10 active level", wait_o, 0);
        hold(2); idle(3);
        wait_hi = 1'b1;

        // R11 abort during stall, then quiet end during data
        tag = "R11"; latency = 3'd4;
        go(16'h0060, 1'b1);
        hold(1);
        idle(1);
        idle(1); chk(obs_cor, "R11 corruption flag", obs_cor, 1);
        idle(1); chk(!obs_cor && !obs_wait, "R11 burst aborted", obs_cor, 0);
        go(16'h0060, 1'b1);
        hold(4);
        idle(1);
        idle(1); chk(!obs_cor, "R11 no flag on data end", obs_cor, 0);
        idle(2);

        // R12 address valid ignored mid-burst
        tag = "R12"; latency = 3'd2;
        go(16'h0040, 1'b1);
        hold(1);
        tick(1'b0, 1'b0, 1'b0, 16'h0999, 1'b0);
        hold(1); chk(obs_rd && obs_col == 16'h0041, "R12 column kept", obs_col, 16'h0041);
        hold(1); idle(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule